// File: doc/BRIEF.md
# Leading Zero Anticipator with Normalizer

This block sits in the sum path of a fused multiply-add datapath, beside the wide adder. It receives the two aligned operands that enter the adder and an effective-subtract control. From those two operands alone it predicts how far the adder's result must be shifted left to bring its leading one to the top. Because the prediction does not depend on the sum, it is formed while the addition is still in progress.

Per-bit propagate, generate and kill terms of the operand pair build an indicator string. A priority encoder turns that string into a predicted shift count. The prediction is either exact or one position short. The sum from the adder is shifted by the prediction, and its top bit is then inspected. If that bit is zero, one more shift is applied and the reported count is raised by one. An all-zero sum raises a zero flag and reports a count equal to the width.

The caller keeps the true result non-negative and within the width. In add mode the sum of the operands must not carry out. In subtract mode the first operand must not be smaller than the second. The sum input is the adder's result for the same operands and mode.

Top module: `lza_normalizer`

## Requirements
- R1: For a non-zero sum, `norm_out` equals `sum_in` shifted left by `shift_cnt`, and `norm_out[WIDTH-1]` is 1.
- R2: In add mode (`eff_sub`=0, `sum_in`=`op_a`+`op_b` with no carry out), `shift_cnt` equals the number of leading zeros of `sum_in`.
- R3: In subtract mode (`eff_sub`=1, `op_b` used inverted with a carry-in of one, so `sum_in`=`op_a`-`op_b` with `op_a`>=`op_b`), `shift_cnt` equals the number of leading zeros of `sum_in`. This includes heavy cancellation where the operands agree in many upper bits.
- R4: When `sum_in` is all zeros, `sum_zero` is 1, `shift_cnt` equals WIDTH and `norm_out` is zero.
- R5: `sum_zero` is 0 whenever `sum_in` is non-zero.
- R6: The count predicted from the operands equals the final `shift_cnt` or falls short of it by exactly one. A one-short prediction is repaired by one extra left shift.
- R7: A sum whose top bit is already set gives `shift_cnt`=0 and `norm_out`=`sum_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First aligned adder operand |
| op_b | input | WIDTH | Second aligned adder operand (not yet inverted) |
| eff_sub | input | 1 | 1 selects effective subtraction, 0 selects addition |
| sum_in | input | WIDTH | Adder result for the same operands and mode |
| norm_out | output | WIDTH | Sum shifted left so that its leading one is the top bit |
| shift_cnt | output | $clog2(WIDTH+1) | Applied left-shift amount; WIDTH for a zero sum |
| sum_zero | output | 1 | Sum is all zeros |

## Verification
The bench builds the block with WIDTH left at its default of 16. This makes every shift count from 0 to 16 reachable with directed operand pairs, including a leading one at each bit position, in both add and subtract mode. At 16 bits, random operand pairs often produce results that need the one-position repair. Subtract cases with nearly equal operands drive the heavy-cancellation counts near the width, which a wider build would rarely reach at random.

// File: rtl/lza_pkg.sv
// Package: shared types for the leading zero anticipator.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package lza_pkg;

    // Per-bit classification of an operand pair
    typedef struct packed {
        logic t;   // exactly one operand bit set (propagate)
        logic g;   // both operand bits set (generate)
        logic z;   // neither operand bit set (kill)
    } pgk_t;

    // Classify one bit pair
    function automatic pgk_t classify(input logic x, input logic y);
        pgk_t r;
        r.t = x ^ y;
        r.g = x & y;
        r.z = ~x & ~y;
        return r;
    endfunction

endpackage

// File: rtl/lza_indicator.sv
// Module: lza_indicator
// Builds the leading-one indicator string from the two adder operands.
// The operands are extended by one low bit that carries the carry-in, so the
// extended sum is exact, and by two high sign bits. Each indicator bit looks
// at the propagate term one position up and the generate/kill terms at its
// own and the next lower position. The marked leading one lands at the true
// position or one above it. Assumes a non-negative true result.
module lza_indicator #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             eff_sub,
    output logic [WIDTH-1:0] ind
);
    import lza_pkg::*;

    localparam int EW = WIDTH + 3;

    logic [EW-1:0] ext_a;
    logic [EW-1:0] ext_b;
    pgk_t [EW-1:0] cls;
    logic [EW-1:0] f;

    // Extend operands: carry-in bit at the bottom, sign bits at the top
    always_comb begin
        ext_a = {2'b00, op_a, eff_sub};
        ext_b = {{2{eff_sub}}, (eff_sub ? ~op_b : op_b), eff_sub};
    end

    genvar i;
    generate
        for (i = 0; i < EW; i++) begin : g_cls
            assign cls[i] = classify(ext_a[i], ext_b[i]);
        end

        assign f[0]      = 1'b0;
        assign f[EW-1]   = 1'b0;
        for (i = 1; i < EW - 1; i++) begin : g_f
            assign f[i] = cls[i+1].t
                ? ((cls[i].g & ~cls[i-1].z) | (cls[i].z & ~cls[i-1].g))
                : ((cls[i].z & ~cls[i-1].z) | (cls[i].g & ~cls[i-1].g));
        end

        for (i = 0; i < WIDTH - 1; i++) begin : g_map
            assign ind[i] = f[i+1];
        end
    endgenerate

    // Top indicator bit also absorbs a mark one above the data range
    assign ind[WIDTH-1] = f[WIDTH] | f[WIDTH+1];

endmodule

// File: rtl/lza_lead_enc.sv
// Module: lza_lead_enc
// Priority encoder: reports WIDTH-1 minus the index of the most significant
// set indicator bit. Reports zero when no bit is set.
module lza_lead_enc #(
    parameter int WIDTH = 16,
    parameter int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] ind,
    output logic [CNT_W-1:0] cnt
);

    // Scan upward so the highest set bit decides the count
    always_comb begin
        cnt = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (ind[i]) cnt = CNT_W'(WIDTH - 1 - i);
        end
    end

endmodule

// File: rtl/lza_shift.sv
// Module: lza_shift
// Logarithmic left shifter: one stage per bit of the shift amount.
// Stages whose step reaches the width clear the data.
module lza_shift #(
    parameter int WIDTH = 16,
    parameter int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [CNT_W-1:0] amt,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage [CNT_W+1];

    assign stage[0] = din;

    genvar k;
    generate
        for (k = 0; k < CNT_W; k++) begin : g_stage
            if ((1 << k) >= WIDTH) begin : g_clear
                assign stage[k+1] = amt[k] ? '0 : stage[k];
            end else begin : g_move
                assign stage[k+1] = amt[k] ? (stage[k] << (1 << k)) : stage[k];
            end
        end
    endgenerate

    assign dout = stage[CNT_W];

endmodule

// File: rtl/lza_normalizer.sv
// Module: lza_normalizer (top)
// Predicts the normalization shift from the adder operands, shifts the adder
// sum by the prediction, then repairs a one-short prediction by checking the
// top bit. A zero sum reports a count of WIDTH and a zero flag.
// Assumes sum_in is the adder result for op_a, op_b and eff_sub, and that the
// true result is non-negative and fits in WIDTH bits.
module lza_normalizer #(
    parameter int WIDTH = 16,
    parameter int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             eff_sub,
    input  logic [WIDTH-1:0] sum_in,
    output logic [WIDTH-1:0] norm_out,
    output logic [CNT_W-1:0] shift_cnt,
    output logic             sum_zero
);

    logic [WIDTH-1:0] ind;
    logic [CNT_W-1:0] pred_cnt;
    logic [WIDTH-1:0] coarse;
    logic             fix_one;

    lza_indicator #(.WIDTH(WIDTH)) u_ind (
        .op_a    (op_a),
        .op_b    (op_b),
        .eff_sub (eff_sub),
        .ind     (ind)
    );

    lza_lead_enc #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_enc (
        .ind (ind),
        .cnt (pred_cnt)
    );

    lza_shift #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_shift (
        .din  (sum_in),
        .amt  (pred_cnt),
        .dout (coarse)
    );

    // Detect a one-short prediction and produce the final result
    always_comb begin
        sum_zero = (sum_in == '0);
        fix_one  = ~coarse[WIDTH-1];
        if (sum_zero) begin
            norm_out  = '0;
            shift_cnt = CNT_W'(WIDTH);
        end else if (fix_one) begin
            norm_out  = coarse << 1;
            shift_cnt = pred_cnt + CNT_W'(1);
        end else begin
            norm_out  = coarse;
            shift_cnt = pred_cnt;
        end
    end

endmodule

// File: rtl/lza_normalizer_chk.sv
// Module: lza_normalizer_chk
// Checker for lza_normalizer, attached by bind. The block is combinational,
// so the checks are immediate assertions evaluated whenever inputs settle.
module lza_normalizer_chk #(
    parameter int WIDTH = 16,
    parameter int CNT_W = $clog2(WIDTH + 1)
) (
    input logic [WIDTH-1:0] sum_in,
    input logic [WIDTH-1:0] norm_out,
    input logic [CNT_W-1:0] shift_cnt,
    input logic             sum_zero,
    input logic [CNT_W-1:0] pred_cnt
);

    // Evaluate all result invariants on every input change
    always_comb begin
        // R1
        norm_msb_chk: assert (sum_zero || norm_out[WIDTH-1])
            else $error("normalized top bit not set");
        // R1
        norm_shift_chk: assert (sum_zero || norm_out == (sum_in << shift_cnt))
            else $error("normalized value does not match shifted sum");
        // R4
        zero_cnt_chk: assert (!sum_zero || (shift_cnt == CNT_W'(WIDTH) && norm_out == '0))
            else $error("zero sum reported wrong count or value");
        // R6
        pred_window_chk: assert (sum_zero || shift_cnt == pred_cnt
                                 || shift_cnt == CNT_W'(pred_cnt + CNT_W'(1)))
            else $error("prediction outside one-position window");
    end

endmodule

bind lza_normalizer lza_normalizer_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
    .sum_in    (sum_in),
    .norm_out  (norm_out),
    .shift_cnt (shift_cnt),
    .sum_zero  (sum_zero),
    .pred_cnt  (pred_cnt)
);

// File: tb/lza_normalizer_tb.sv
// Bench: directed scenarios, one task each, each checking its own results.
module lza_normalizer_tb;

    localparam int W  = 16;
    localparam int CW = $clog2(W + 1);

    logic          clk = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic          eff_sub = 1'b0;
    logic [W-1:0]  sum_in = '0;
    logic [W-1:0]  norm_out;
    logic [CW-1:0] shift_cnt;
    logic          sum_zero;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;   // 250 MHz

    lza_normalizer #(.WIDTH(W)) u_dut (
        .op_a      (op_a),
        .op_b      (op_b),
        .eff_sub   (eff_sub),
        .sum_in    (sum_in),
        .norm_out  (norm_out),
        .shift_cnt (shift_cnt),
        .sum_zero  (sum_zero)
    );

    // Watchdog: end a hung run as a failure
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    // Reference leading-zero count of a value
    function automatic int ref_clz(input logic [W-1:0] v);
        int n = W;
        for (int i = 0; i < W; i++) if (v[i]) n = W - 1 - i;
        return n;
    endfunction

    // Drive one operand pair away from the clock edge, then compare outputs
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic sub, input string req);
        logic [W-1:0] s;
        int           exp_cnt;
        logic [W-1:0] exp_out;
        @(negedge clk);
        s = sub ? (a - b) : (a + b);
        op_a = a; op_b = b; eff_sub = sub; sum_in = s;
        #1;
        exp_cnt = ref_clz(s);
        exp_out = (exp_cnt >= W) ? '0 : (s << exp_cnt);
        n_chk = n_chk + 1;
        if (int'(shift_cnt) != exp_cnt || norm_out != exp_out || sum_zero != (s == '0)) begin
            n_bad = n_bad + 1;
            $display("FAIL %s a=%h b=%h sub=%0d: cnt=%0d out=%h z=%0d expected cnt=%0d out=%h z=%0d",
                     req, a, b, sub, shift_cnt, norm_out, sum_zero, exp_cnt, exp_out, s == '0);
        end
    endtask

    // Idle state: all-zero inputs give the zero result (R4)
    task automatic t_idle();
        #1;
        n_chk = n_chk + 1;
        if (!sum_zero || int'(shift_cnt) != W || norm_out != '0) begin
            n_bad = n_bad + 1;
            $display("FAIL R4 idle: cnt=%0d out=%h z=%0d expected cnt=%0d out=0 z=1",
                     shift_cnt, norm_out, sum_zero, W);
        end
    endtask

    // Add mode: leading one walked through every position (R2, R1, R6)
    task automatic t_add_walk();
        for (int p = 0; p < W; p++) begin
            apply(W'(1) << p, '0, 1'b0, "R2 walk");
            if (p > 0) apply(W'(1) << (p - 1), W'(1) << (p - 1), 1'b0, "R6 carry");
        end
        apply(16'h0001, 16'h0000, 1'b0, "R6 short prediction");
    endtask

    // Subtract mode with heavy cancellation (R3, R6)
    task automatic t_sub_cancel();
        for (int p = 0; p < W; p++) begin
            apply(16'h8000, 16'h8000 - (W'(1) << p), 1'b1, "R3 cancel");
        end
        apply(16'h0100, 16'h00FF, 1'b1, "R3 borrow chain");
        apply(16'hFFFF, 16'hFFFE, 1'b1, "R3 near equal");
        apply(16'h0004, 16'h0003, 1'b1, "R3 small");
    endtask

    // Zero sums in both modes (R4)
    task automatic t_zero();
        apply('0, '0, 1'b0, "R4 add zero");
        apply(16'h1234, 16'h1234, 1'b1, "R4 sub equal");
        apply(16'hFFFF, 16'hFFFF, 1'b1, "R4 sub all ones");
    endtask

    // Non-zero sums must not raise the zero flag (R5)
    task automatic t_nonzero_flag();
        apply(16'h0000, 16'h0001, 1'b0, "R5 lsb only");
        apply(16'h8001, 16'h8000, 1'b1, "R5 sub lsb");
    endtask

    // Top bit already set needs no shift (R7)
    task automatic t_top_set();
        apply(16'h8000, 16'h0000, 1'b0, "R7 add top");
        apply(16'h7FFF, 16'h0001, 1'b0, "R7 add carry to top");
        apply(16'hFFFF, 16'h0000, 1'b1, "R7 sub top");
    endtask

    // Random operand pairs within the non-negative, no-overflow range (R1, R2, R3)
    task automatic t_random();
        for (int n = 0; n < 2000; n++) begin
            int unsigned a = $urandom_range(W'(-1), 0) >> $urandom_range(W - 1, 0);
            int unsigned bmax = (1 << W) - 1 - a;
            apply(W'(a), W'($urandom_range(bmax, 0) >> $urandom_range(W - 1, 0)), 1'b0, "R2 random add");
            apply(W'(a), W'(a - $urandom_range(a, 0)), 1'b1, "R3 random sub");
            apply(W'(a), W'($urandom_range(a, 0)), 1'b1, "R1 random sub");
        end
    endtask

    initial begin
        t_idle();
        t_add_walk();
        t_sub_cancel();
        t_zero();
        t_nonzero_flag();
        t_top_set();
        t_random();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule